// File: doc/BRIEF.md
# Multi-Channel Disk Host Adapter Register Bank

This block holds the software-visible registers of a host adapter that serves up to eight disk channels. Each channel has six 32-bit words: an interrupt status word, an interrupt enable word, a control word, a command-issue bitmap and two plain base-address words. Software reaches them through one word-wide request port with a registered read response. The channel engines report each finished command slot through a one-cycle completion pulse that carries the slot number and a failure flag.

Completion pulses update the channel's state in two ways. The slot's bit in the command-issue bitmap is cleared. A status bit is set, and that bit can raise the channel's interrupt line. Software can only add bits to the issue bitmap, so a slot that is still in flight is never dropped by a bus write.

Request back-pressure: a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is being held because `rsp_ready` is low. A read response stays on `rsp_valid`/`rsp_rdata`, unchanged, until it is taken with `rsp_ready`. Writes never produce a response.

Top module: `sata_hba_regs`

## Requirements
- R1: The channel is selected by address bits [14:12] and the word by bits [4:2]. Word codes are 0 status, 1 enable, 2 control, 3 issue, 4 list base and 5 buffer base. Codes 6 and 7, and any channel number at or above the channel count, read as zero and ignore writes. All other address bits are ignored.
- R2: The enable word stores only bits 0 and 30. Every other bit reads as zero, whatever value is written.
- R3: A channel's `irq` bit is high whenever status bit 0 and enable bit 0 are both set, or status bit 30 and enable bit 30 are both set.
- R4: A write to the issue word stores the bitwise OR of the write data and the current contents.
- R5: A completion pulse clears the issue bit of the reported slot, whether the command succeeded or failed.
- R6: If a write sets an issue bit in the same cycle that a completion clears it, the bit ends up cleared.
- R7: A successful completion sets status bit 0 and a failed one sets status bit 30; all other status bits stay zero. Writing a 1 to a status bit clears it. A hardware set in the same cycle as a software clear leaves the bit set.
- R8: Read data appears on `rsp_rdata` with `rsp_valid` in the cycle after the request is accepted. It shows the register contents as they were before any update made in that same cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response holds its data.
- R10: `irq_any` is the OR of all per-channel `irq` bits.
- R11: A synchronous active-low reset clears every register, the response and all interrupt outputs.
- R12: The control and both base words are plain 32-bit read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address within the adapter window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read data |
| done_valid | input | NCH | Per-channel completion pulse |
| done_slot | input | NCH*5 | Per-channel completed slot number |
| done_err | input | NCH | Per-channel completion failed |
| irq | output | NCH | Per-channel interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
The assertions assume a few things about the inputs. A completion pulse's slot number is meaningful only while its pulse is high. Request fields are meaningful only while `req_valid` is high. The bench drives completion pulses for exactly one cycle, always with a valid slot number. It drops `req_valid` right after each accepted request, and it raises it only when `req_ready` is high, except in one back-pressure case where it is meant to be held off. Write-plus-completion collisions are created on purpose, so the clear-wins and set-wins rules are exercised in the same cycle.

// File: rtl/sata_hba_pkg.sv
package sata_hba_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OK_BIT   = 0;
  localparam int unsigned ERR_BIT  = 30;

  typedef enum logic [2:0] {
    RG_STAT  = 3'd0,
    RG_IEN   = 3'd1,
    RG_CTRL  = 3'd2,
    RG_ISSUE = 3'd3,
    RG_LBASE = 3'd4,
    RG_BBASE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/sata_chan_regs.sv
module sata_chan_regs
  import sata_hba_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [DW-1:0]     wdata,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic              done_err,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam logic [DW-1:0] IRQ_MASK = (DW'(1) << OK_BIT) | (DW'(1) << ERR_BIT);

  logic [DW-1:0] stat_q, ien_q, ctrl_q, issue_q, lbase_q, bbase_q;
  logic [DW-1:0] hw_set, hw_clr;
  logic [DW-1:0] stat_d, issue_d;

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    if (done_valid) begin
      hw_set = done_err ? (DW'(1) << ERR_BIT) : (DW'(1) << OK_BIT);
      hw_clr = DW'(1) << done_slot;
    end
  end

  always_comb begin
    stat_d  = stat_q;
    issue_d = issue_q;
    if (wr_en && sel == RG_STAT)  stat_d  = stat_q & ~(wdata & IRQ_MASK);
    if (wr_en && sel == RG_ISSUE) issue_d = issue_q | wdata;
    stat_d  = stat_d | hw_set;
    issue_d = issue_d & ~hw_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ien_q   <= '0;
      ctrl_q  <= '0;
      issue_q <= '0;
      lbase_q <= '0;
      bbase_q <= '0;
    end else begin
      stat_q  <= stat_d;
      issue_q <= issue_d;
      if (wr_en && sel == RG_IEN)   ien_q   <= wdata & IRQ_MASK;
      if (wr_en && sel == RG_CTRL)  ctrl_q  <= wdata;
      if (wr_en && sel == RG_LBASE) lbase_q <= wdata;
      if (wr_en && sel == RG_BBASE) bbase_q <= wdata;
    end
  end

  always_comb begin
    case (sel)
      RG_STAT:  rd_data = stat_q;
      RG_IEN:   rd_data = ien_q;
      RG_CTRL:  rd_data = ctrl_q;
      RG_ISSUE: rd_data = issue_q;
      RG_LBASE: rd_data = lbase_q;
      RG_BBASE: rd_data = bbase_q;
      default:  rd_data = '0;
    endcase
  end

  assign irq = |(stat_q & ien_q & IRQ_MASK);

  // R5
  ci_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> issue_q[$past(done_slot)] == 1'b0);

  // R4
  ci_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RG_ISSUE && !done_valid) |=> issue_q == ($past(issue_q) | $past(wdata)));

  // R7
  stat_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_err) |=> stat_q[OK_BIT]);

  // R7
  stat_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_err) |=> stat_q[ERR_BIT]);
endmodule

// File: rtl/sata_rsp_stage.sv
module sata_rsp_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          can_accept
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_valid);
endmodule

// File: rtl/sata_hba_regs.sv
module sata_hba_regs
  import sata_hba_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned AW     = 15,
  parameter int unsigned DW     = 32,
  parameter int unsigned SLOT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DW-1:0]         rsp_rdata,
  input  logic [NCH-1:0]        done_valid,
  input  logic [NCH*SLOT_W-1:0] done_slot,
  input  logic [NCH-1:0]        done_err,
  output logic [NCH-1:0]        irq,
  output logic                  irq_any
);
  localparam int unsigned CH_LSB  = 12;
  localparam int unsigned CH_W    = 3;
  localparam int unsigned REG_LSB = 2;
  localparam int unsigned REG_W   = 3;

  logic [CH_W-1:0]  ch_sel;
  logic [REG_W-1:0] reg_sel;
  logic             accept;
  logic [DW-1:0]    chan_rd [NCH];
  logic [DW-1:0]    rd_word;

  assign ch_sel  = req_addr[CH_LSB +: CH_W];
  assign reg_sel = req_addr[REG_LSB +: REG_W];
  assign accept  = req_valid && req_ready;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sata_chan_regs #(.DW(DW), .SLOT_W(SLOT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (accept && req_write && (ch_sel == CH_W'(i))),
      .sel        (reg_sel),
      .wdata      (req_wdata),
      .done_valid (done_valid[i]),
      .done_slot  (done_slot[i*SLOT_W +: SLOT_W]),
      .done_err   (done_err[i]),
      .rd_data    (chan_rd[i]),
      .irq        (irq[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCH; i++)
      if (ch_sel == CH_W'(i)) rd_word = chan_rd[i];
  end

  sata_rsp_stage #(.DW(DW)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept && !req_write),
    .load_data  (rd_word),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_rdata),
    .can_accept (req_ready)
  );

  assign irq_any = |irq;

  // R9
  no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/sata_hba_regs_test.sv
module sata_hba_regs_test;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq_any;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] done_valid = '0, done_err = '0, irq;
  logic [NCH*5-1:0] done_slot = '0;

  sata_hba_regs uut (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] m[NCH][8];
  localparam logic [31:0] MASK = 32'h4000_0001;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid && rsp_ready) begin
    if (exp_q.size() == 0) chk("R8 unexpected response", rsp_rdata, 32'hx);
    else begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, rsp_rdata, e);
    end
  end

  function automatic logic [14:0] mk(int ch, int rg);
    return {3'(ch), 7'b0, 3'(rg), 2'b0};
  endfunction

  function automatic void m_wr(int ch, int rg, logic [31:0] d);
    if (ch >= NCH) return;
    case (rg)
      0: m[ch][0] = m[ch][0] & ~(d & MASK);
      1: m[ch][1] = d & MASK;
      3: m[ch][3] = m[ch][3] | d;
      2, 4, 5: m[ch][rg] = d;
      default: ;
    endcase
  endfunction

  function automatic void m_done(int ch, int slot, bit err);
    m[ch][3][slot] = 1'b0;
    if (err) m[ch][0][30] = 1'b1; else m[ch][0][0] = 1'b1;
  endfunction

  task automatic wr(int ch, int rg, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = mk(ch, rg); req_wdata = d;
    @(posedge clk); #1 req_valid = 0;
    m_wr(ch, rg, d);
  endtask

  task automatic rd(int ch, int rg, string tag);
    exp_q.push_back((ch < NCH && rg < 6) ? m[ch][rg] : 32'h0);
    tag_q.push_back(tag);
    req_valid = 1; req_write = 0; req_addr = mk(ch, rg);
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic done(int ch, int slot, bit err);
    done_valid[ch] = 1; done_slot[ch*5 +: 5] = 5'(slot); done_err[ch] = err;
    @(posedge clk); #1 done_valid[ch] = 0;
    m_done(ch, slot, err);
  endtask

  task automatic coll(int ch, int rg, logic [31:0] d, int slot, bit err);
    req_valid = 1; req_write = 1; req_addr = mk(ch, rg); req_wdata = d;
    done_valid[ch] = 1; done_slot[ch*5 +: 5] = 5'(slot); done_err[ch] = err;
    @(posedge clk); #1 req_valid = 0; done_valid[ch] = 0;
    m_wr(ch, rg, d);
    m_done(ch, slot, err);
  endtask

  task automatic chk_irq(string tag);
    logic [NCH-1:0] e;
    for (int c = 0; c < NCH; c++) e[c] = |(m[c][0] & m[c][1] & MASK);
    chk({tag, " irq"}, 32'(irq), 32'(e));
    chk("R10 irq_any", 32'(irq_any), 32'(|e));
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    for (int c = 0; c < NCH; c++) for (int r = 0; r < 8; r++) m[c][r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    for (int r = 0; r < 6; r++) rd(0, r, "R11 reset read");
    chk_irq("R11");
    // R2 enable mask
    wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, "R2 enable mask");
    // R12 plain storage
    wr(0, 2, 32'hA5A5_1234); wr(0, 4, 32'hDEAD_BEEF); wr(0, 5, 32'h0BAD_F00D);
    rd(0, 2, "R12 control"); rd(0, 4, "R12 list base"); rd(0, 5, "R12 buffer base");
    // R4 OR write
    wr(0, 3, 32'h0000_000F); wr(0, 3, 32'h0000_00F0); rd(0, 3, "R4 issue OR");
    // R5, R7, R3 successful completion
    done(0, 3, 0); rd(0, 3, "R5 issue cleared"); rd(0, 0, "R7 status ok bit");
    chk_irq("R3 ok");
    // failed completion
    done(0, 4, 1); rd(0, 3, "R5 issue cleared on error"); rd(0, 0, "R7 status err bit");
    // R7 W1C on bit 0 only
    wr(0, 0, 32'h0000_0001); rd(0, 0, "R7 write-one-clear");
    chk_irq("R3 err only");
    wr(0, 1, 32'h0000_0001); chk_irq("R3 err masked");
    wr(0, 0, 32'hFFFF_FFFF); rd(0, 0, "R7 all cleared"); chk_irq("R3 none");
    // R6 collision: set and clear of slot 9
    coll(0, 3, 32'h0000_0200, 9, 0); rd(0, 3, "R6 clear wins");
    // R7 collision: clear bit 0 while hardware sets it
    coll(0, 0, 32'h0000_0001, 1, 0); rd(0, 0, "R7 set wins");
    chk_irq("R3 after collision");
    // R1 unused offsets and channel separation
    wr(0, 6, 32'h1111_1111); wr(0, 7, 32'h2222_2222);
    rd(0, 6, "R1 offset 6 zero"); rd(0, 7, "R1 offset 7 zero");
    wr(7, 2, 32'h7777_0007); rd(7, 2, "R1 channel 7 control"); rd(0, 2, "R1 channel 0 untouched");
    req_valid = 1; req_write = 0; req_addr = mk(5, 3) | 15'h0FE0;
    exp_q.push_back(m[5][3]); tag_q.push_back("R1 ignored address bits");
    @(posedge clk); #1 req_valid = 0;
    // R10 other channel interrupt
    wr(5, 1, MASK); done(5, 0, 1); chk_irq("R3 ch5");
    // R8 / R9 back-pressure
    rsp_ready = 0;
    rd(7, 2, "R9 held response");
    repeat (3) @(posedge clk);
    #1 chk("R9 rsp_valid held", 32'(rsp_valid), 32'h1);
    chk("R9 data held", rsp_rdata, 32'h7777_0007);
    chk("R9 req_ready low", 32'(req_ready), 32'h0);
    rsp_ready = 1;
    repeat (4) @(posedge clk);
    #1 chk("R8 all responses seen", 32'(exp_q.size()), 32'h0);
    finish_up();
  end
endmodule